// File: doc/BRIEF.md
# Scanline XOR-Toggle Area Fill

This block turns a single-plane outline bitmap into solid horizontal spans. Each word of a row enters as one 16-bit value per cycle, in right-to-left order. This is the order a descending traversal of the bitmap delivers, with the bottom row first. Inside each word the block scans the bits from the least significant upward. It keeps a one-bit fill carry that flips at every set outline pixel. Pixels that lie between a pair of outline pixels on the same row therefore come out set.

There are two fill flavours. The inclusive flavour keeps both edge pixels of every span. The exclusive flavour drops the left-hand edge pixel of every span. When neither flavour is selected, words pass straight through. The carry runs from one word into the next word of the same row. A row-start strobe reloads the carry from a programmable seed before the rightmost word of each row. The filled word appears one cycle after its input word.

The outline must hold exactly one set pixel per row for each edge. Memory addressing and line drawing belong to other blocks.

Top module: `area_fill_unit`

## Requirements
- R1: While reset is held and after it is released, `outValid` is 0 and `outWord` is all zeros until the first accepted word.
- R2: Every cycle with `inValid` high yields exactly one output word, with `outValid` high in the following cycle. In a cycle after `inValid` was low, `outValid` is low and `outWord` keeps its previous value.
- R3: Bits are scanned from bit 0 up to bit 15. The carry entering bit i+1 equals the carry entering bit i XOR input bit i.
- R4: Inclusive mode (`modeInclusive`=1): output bit i = input bit i OR the carry entering bit i. The carry out of the word is the carry leaving bit 15.
- R5: Exclusive mode (`modeExclusive`=1, `modeInclusive`=0): output bit i equals the carry leaving bit i, which is the carry entering bit i XOR input bit i.
- R6: When both mode inputs are 1, inclusive mode applies.
- R7: When both mode inputs are 0, the output word equals the input word and the fill carry is not changed. A later filled word in the same row sees the carry from before the pass-through word.
- R8: The carry leaving bit 15 of one accepted word is the carry entering bit 0 of the next accepted word of the row. Idle cycles between the two words leave it unchanged.
- R9: A word accepted with `rowStart`=1 uses `carrySeed` as its entering carry. A `rowStart` pulse without `inValid` loads `carrySeed` as the carry for the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | WORD_W | Outline word, rightmost word of the row first |
| inValid | input | 1 | `inWord` is accepted this cycle |
| rowStart | input | 1 | Reload the carry from `carrySeed` for this or the next word |
| modeInclusive | input | 1 | Select inclusive fill |
| modeExclusive | input | 1 | Select exclusive fill |
| carrySeed | input | 1 | Carry value at the start of each row |
| outWord | output | WORD_W | Filled word, one cycle after acceptance |
| outValid | output | 1 | `outWord` carries a new result |

## Verification
The bench targets spans that cross a word boundary. A design that drops or inverts the carry between words would leave the left part of such a span empty. It feeds pass-through words in the middle of a row. A design that updates the carry on those words would fill the wrong side of the next edge. It also checks that a seed of 1 inverts the spans, that a row-start pulse with no word still reloads the carry, and that inclusive mode wins when both mode inputs are set. Exclusive outputs are compared bit by bit, so a design that drops the wrong edge pixel shows an error at that pixel's position.

// File: rtl/area_fill_pkg.sv
package area_fill_pkg;

  typedef enum logic [1:0] {
    FILL_PASS = 2'd0,
    FILL_INCL = 2'd1,
    FILL_EXCL = 2'd2
  } fillMode_e;

  typedef struct packed {
    logic      takeWord;
    logic      loadSeed;
    fillMode_e mode;
  } fillStrobe_t;

endpackage

// File: rtl/area_fill_ctrl.sv
module area_fill_ctrl
  import area_fill_pkg::*;
(
  input  logic        inValid,
  input  logic        rowStart,
  input  logic        modeInclusive,
  input  logic        modeExclusive,
  output fillStrobe_t strobe
);

  fillMode_e modeSel;

  // inclusive wins when both are requested
  always_comb begin
    if (modeInclusive)      modeSel = FILL_INCL;
    else if (modeExclusive) modeSel = FILL_EXCL;
    else                    modeSel = FILL_PASS;
  end

  always_comb begin
    strobe.takeWord = inValid;
    strobe.loadSeed = rowStart;
    strobe.mode     = modeSel;
  end

endmodule

// File: rtl/area_fill_datapath.sv
module area_fill_datapath
  import area_fill_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobe_t       strobe,
  input  logic [WORD_W-1:0] inWord,
  input  logic              carrySeed,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  localparam int CHAIN_W = WORD_W + 1;

  logic               carryReg;
  logic               entryCarry;
  logic [CHAIN_W-1:0] chain;
  logic [WORD_W-1:0]  inclWord;
  logic [WORD_W-1:0]  exclWord;
  logic [WORD_W-1:0]  nextWord;
  logic               nextCarry;

  assign entryCarry = strobe.loadSeed ? carrySeed : carryReg;
  assign chain[0]   = entryCarry;

  // ripple from bit 0 (rightmost pixel) toward the top bit
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    assign chain[g+1]  = chain[g] ^ inWord[g];
    assign inclWord[g] = inWord[g] | chain[g];
    assign exclWord[g] = chain[g+1];
  end

  always_comb begin
    unique case (strobe.mode)
      FILL_INCL: nextWord = inclWord;
      FILL_EXCL: nextWord = exclWord;
      default:   nextWord = inWord;
    endcase
  end

  // pass-through words leave the carry alone (seed reload still applies)
  assign nextCarry = (strobe.takeWord && strobe.mode != FILL_PASS)
                     ? chain[WORD_W] : entryCarry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryReg <= 1'b0;
      outWord  <= '0;
      outValid <= 1'b0;
    end else begin
      carryReg <= nextCarry;
      outValid <= strobe.takeWord;
      if (strobe.takeWord) outWord <= nextWord;
    end
  end

endmodule

// File: rtl/area_fill_unit.sv
module area_fill_unit
  import area_fill_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  input  logic              rowStart,
  input  logic              modeInclusive,
  input  logic              modeExclusive,
  input  logic              carrySeed,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid
);

  fillStrobe_t strobe;

  area_fill_ctrl u_ctrl (
    .inValid       (inValid),
    .rowStart      (rowStart),
    .modeInclusive (modeInclusive),
    .modeExclusive (modeExclusive),
    .strobe        (strobe)
  );

  area_fill_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inWord    (inWord),
    .carrySeed (carrySeed),
    .outWord   (outWord),
    .outValid  (outValid)
  );

endmodule

// File: rtl/area_fill_checker.sv
module area_fill_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] inWord,
  input logic              inValid,
  input logic              rowStart,
  input logic              modeInclusive,
  input logic              modeExclusive,
  input logic              carrySeed,
  input logic [WORD_W-1:0] outWord,
  input logic              outValid
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outWord)));

  // R7
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !modeInclusive && !modeExclusive) |=> outWord == $past(inWord));

  // R4
  incl_keeps_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeInclusive) |=> (outWord & $past(inWord)) == $past(inWord));

  // R5
  excl_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rowStart && modeExclusive && !modeInclusive && !carrySeed)
      |=> outWord[WORD_W-1] == ^$past(inWord));

  // R9
  seed_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rowStart && modeInclusive) |=> outWord[0] == ($past(inWord[0]) | $past(carrySeed)));

endmodule

bind area_fill_unit area_fill_checker #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/area_fill_unit_test.sv
module area_fill_unit_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] inWord = '0;
  logic         inValid = 1'b0;
  logic         rowStart = 1'b0;
  logic         modeInclusive = 1'b0;
  logic         modeExclusive = 1'b0;
  logic         carrySeed = 1'b0;
  logic [W-1:0] outWord;
  logic         outValid;

  int checks = 0;
  int fails = 0;
  logic mCarry = 1'b0;
  logic [W-1:0] lastOut = '0;

  always #4 clk = ~clk;

  area_fill_unit #(.WORD_W(W)) uut (.*);

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference: inc/exc from mode bits; returns filled word and new carry
  task automatic model(input logic [W-1:0] w, input logic cin, input logic inc,
                       input logic exc, output logic [W-1:0] o, output logic cout);
    logic c;
    c = cin;
    for (int i = 0; i < W; i++) begin
      if (inc)      o[i] = w[i] | c;
      else if (exc) o[i] = w[i] ^ c;
      else          o[i] = w[i];
      c = c ^ w[i];
    end
    cout = (inc || exc) ? c : cin;
  endtask

  task automatic send(input string tag, input logic [W-1:0] w, input logic rs,
                      input logic inc, input logic exc, input logic seed);
    logic [W-1:0] expW;
    logic cin;
    @(negedge clk);
    inWord = w; inValid = 1'b1; rowStart = rs;
    modeInclusive = inc; modeExclusive = exc; carrySeed = seed;
    cin = rs ? seed : mCarry;
    model(w, cin, inc, exc, expW, mCarry);
    @(posedge clk); #2;
    chk({tag, " valid"}, {15'd0, outValid}, 16'd1);
    chk(tag, outWord, expW);
    lastOut = expW;
    @(negedge clk);
    inValid = 1'b0; rowStart = 1'b0;
  endtask

  task automatic idle(input logic rs, input logic seed);
    @(negedge clk);
    inValid = 1'b0; rowStart = rs; carrySeed = seed;
    if (rs) mCarry = seed;
    @(posedge clk); #2;
    chk("R2 idle valid", {15'd0, outValid}, 16'd0);
    chk("R2 idle hold", outWord, lastOut);
    @(negedge clk);
    rowStart = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    // R1
    chk("R1 reset valid", {15'd0, outValid}, 16'd0);
    chk("R1 reset word", outWord, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1 after release", outWord, 16'h0000);

    // R4 single-word span
    send("R4 span incl", 16'h0810, 1, 1, 0, 0);
    chk("R4 span value", lastOut, 16'h0FF0);
    // R5 same span exclusive: left edge dropped
    send("R5 span excl", 16'h0810, 1, 0, 1, 0);
    chk("R5 span value", lastOut, 16'h07F0);
    // R6 both modes -> inclusive
    send("R6 both set", 16'h0810, 1, 1, 1, 0);
    chk("R6 value", lastOut, 16'h0FF0);
    // R8 cross-word span with an idle gap
    send("R8 word1", 16'h0010, 1, 1, 0, 0);
    idle(0, 0);
    send("R8 word2", 16'h0100, 0, 1, 0, 0);
    chk("R8 value", lastOut, 16'h01FF);
    // R7 pass-through mid-row keeps carry
    send("R7 open", 16'h0001, 1, 0, 1, 0);
    send("R7 pass", 16'h1234, 0, 0, 0, 0);
    chk("R7 value", lastOut, 16'h1234);
    send("R7 after", 16'h0000, 0, 0, 1, 0);
    chk("R7 carry kept", lastOut, 16'hFFFF);
    // R9 seed 1 and rowStart without a word
    send("R9 seed1", 16'h0000, 1, 1, 0, 1);
    chk("R9 seed1 value", lastOut, 16'hFFFF);
    idle(1, 0);
    send("R9 strobe-only reload", 16'h0000, 0, 1, 0, 1);
    chk("R9 reload value", lastOut, 16'h0000);
    // R3 bit order: edge at bit 15 only
    send("R3 top bit", 16'h8000, 1, 1, 0, 0);
    chk("R3 value", lastOut, 16'h8000);

    // random rows: R3 R4 R5 R7 R8 R9
    for (int n = 0; n < 600; n++) begin
      logic [3:0] sel;
      sel = 4'($urandom);
      if (sel == 0) idle(1'($urandom), 1'($urandom));
      else send("R3/R8 random", 16'($urandom), (sel < 4), 1'($urandom),
                1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule